// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Controller

This block is the hazard control for the decode stage of a five-stage pipeline. It produces four steering signals: the program counter write enable, the fetch/decode register write enable, a bubble request, and an instruction flush. The bubble request clears the control fields captured into the decode/execute register. The flush replaces the word captured into the fetch/decode register with the all-zero no-op word.

A load sitting in the execute stage whose destination register is named by the instruction in decode forces a single stall. The program counter and the fetch/decode register hold their contents, and a do-nothing instruction goes forward into execute.

Branches are resolved in decode. An equality comparator outside the block reports whether the two decode operands match, so a taken branch costs one cycle. A taken branch, or any jump, flushes the fetched instruction and redirects fetch to the target. Branches are otherwise treated as not taken. A stall always wins over a redirect, and the branch is evaluated again once its operands are ready.

Top module: `hzd_ctrl`

## Requirements
- R1: A stall is raised whenever `ex_is_load` is 1 and `ex_rt` equals `id_rs` or `id_rt`.
- R2: While a stall is raised, `pc_we` and `ifid_we` are 0 and `idex_bubble` is 1, all within the same cycle.
- R3: When no stall is raised, `pc_we` and `ifid_we` are 1 and `idex_bubble` is 0.
- R4: A branch (`id_is_branch`=1) with no stall is taken when the operand comparison meets its sense. A taken branch drives `if_flush`=1 and `pc_redirect`=1.
- R5: A branch that is not taken drives `if_flush`=0 and `pc_redirect`=0, so fetch continues in sequence.
- R6: A jump (`id_is_jump`=1) with no stall always drives `if_flush`=1 and `pc_redirect`=1.
- R7: A stall overrides branch and jump decisions: during a stall, `if_flush`=0 and `pc_redirect`=0.
- R8: The branch sense input works as follows:
  - With `id_br_ne`=0, a branch is taken when `id_ops_equal`=1.
  - With `id_br_ne`=1, a branch is taken when `id_ops_equal`=0.
- R9: A load followed by a dependent instruction yields exactly one bubble. Once a control-zeroed instruction occupies execute (`ex_is_load`=0), the stall drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded properties |
| rst_n | input | 1 | Active-low reset for the embedded properties |
| ex_is_load | input | 1 | Instruction in decode/execute register is a load |
| ex_rt | input | REG_W | Destination register of that load |
| id_rs | input | REG_W | First source register of instruction in decode |
| id_rt | input | REG_W | Second source register of instruction in decode |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_ne | input | 1 | Branch sense: 1 = taken on inequality |
| id_is_jump | input | 1 | Decode instruction is an unconditional jump |
| id_ops_equal | input | 1 | Equality comparator result on the decode operands |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Clear control fields entering execute |
| if_flush | output | 1 | Zero the word captured into fetch/decode |
| pc_redirect | output | 1 | Select the branch/jump target for the next fetch |

## Verification
The properties take for granted that `id_is_branch` and `id_is_jump` are never both 1, since one instruction is a branch or a jump but not both. They also assume that `id_ops_equal` reflects the current decode operands. The random stimulus draws the branch and jump flags from one choice so they stay exclusive. Register numbers are drawn from a small range so that dependencies, and their overlap with branches and jumps, occur often. A directed sequence walks a load and its dependent consumer through two cycles to count the bubbles.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   localparam int DEF_REG_W = 5;

   typedef struct packed {
      logic pc_we;
      logic ifid_we;
      logic bubble;
   } stall_ctl_t;

   typedef struct packed {
      logic flush;
      logic redirect;
   } redir_ctl_t;
endpackage

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
   parameter int REG_W = hzd_pkg::DEF_REG_W
) (
   input  logic             ex_is_load,
   input  logic [REG_W-1:0] ex_rt,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   output logic             stall
);
   initial begin
      if (REG_W < 1 || REG_W > 8) $error("hzd_load_use: REG_W out of range");
   end

   logic hit_rs, hit_rt;
   always_comb begin
      hit_rs = (ex_rt == id_rs);
      hit_rt = (ex_rt == id_rt);
      stall  = ex_is_load && (hit_rs || hit_rt);
   end
endmodule

// File: rtl/hzd_branch_resolve.sv
module hzd_branch_resolve #(
   parameter bit BRANCH_NE_EN = 1'b1
) (
   input  logic id_is_branch,
   input  logic id_br_ne,
   input  logic id_is_jump,
   input  logic id_ops_equal,
   input  logic hold,
   output hzd_pkg::redir_ctl_t ctl
);
   logic cond_met;

   generate
      if (BRANCH_NE_EN) begin : g_two_sense
         assign cond_met = id_br_ne ? !id_ops_equal : id_ops_equal;
      end else begin : g_eq_only
         logic unused_ne;
         assign unused_ne = id_br_ne;
         assign cond_met  = id_ops_equal;
      end
   endgenerate

   logic change_flow;
   always_comb begin
      change_flow  = (id_is_branch && cond_met) || id_is_jump;
      ctl.redirect = change_flow && !hold;
      ctl.flush    = change_flow && !hold;
   end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl #(
   parameter int REG_W        = hzd_pkg::DEF_REG_W,
   parameter bit BRANCH_NE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ex_is_load,
   input  logic [REG_W-1:0] ex_rt,
   input  logic [REG_W-1:0] id_rs,
   input  logic [REG_W-1:0] id_rt,
   input  logic             id_is_branch,
   input  logic             id_br_ne,
   input  logic             id_is_jump,
   input  logic             id_ops_equal,
   output logic             pc_we,
   output logic             ifid_we,
   output logic             idex_bubble,
   output logic             if_flush,
   output logic             pc_redirect
);
   import hzd_pkg::*;

   logic       stall;
   stall_ctl_t sctl;
   redir_ctl_t rctl;

   hzd_load_use #(.REG_W(REG_W)) u_lu (
      .ex_is_load(ex_is_load), .ex_rt(ex_rt),
      .id_rs(id_rs), .id_rt(id_rt), .stall(stall)
   );

   hzd_branch_resolve #(.BRANCH_NE_EN(BRANCH_NE_EN)) u_br (
      .id_is_branch(id_is_branch), .id_br_ne(id_br_ne),
      .id_is_jump(id_is_jump), .id_ops_equal(id_ops_equal),
      .hold(stall), .ctl(rctl)
   );

   always_comb begin
      sctl.pc_we   = !stall;
      sctl.ifid_we = !stall;
      sctl.bubble  = stall;
   end

   assign pc_we       = sctl.pc_we;
   assign ifid_we     = sctl.ifid_we;
   assign idex_bubble = sctl.bubble;
   assign if_flush    = rctl.flush;
   assign pc_redirect = rctl.redirect;

   // Assumed input discipline: branch and jump never coincide.
   p_excl_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(id_is_branch && id_is_jump));

   p_dep_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_is_load && (ex_rt == id_rs || ex_rt == id_rt)) |-> idex_bubble);

   p_hold_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idex_bubble |-> (!pc_we && !ifid_we));

   p_free_flow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_is_load |-> (pc_we && ifid_we && !idex_bubble));

   p_jump_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (id_is_jump && !idex_bubble) |-> (if_flush && pc_redirect));

   p_stall_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idex_bubble |-> (!if_flush && !pc_redirect));

   p_untaken_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_is_jump && !id_is_branch) |-> !if_flush);
endmodule

// File: tb/sim_hzd_ctrl.sv
module sim_hzd_ctrl;
   localparam int RW = 5;

   logic clk = 0, rst_n = 0;
   logic ex_is_load = 0, id_is_branch = 0, id_br_ne = 0, id_is_jump = 0, id_ops_equal = 0;
   logic [RW-1:0] ex_rt = 0, id_rs = 0, id_rt = 0;
   logic pc_we, ifid_we, idex_bubble, if_flush, pc_redirect;

   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   hzd_ctrl #(.REG_W(RW), .BRANCH_NE_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ex_is_load(ex_is_load), .ex_rt(ex_rt),
      .id_rs(id_rs), .id_rt(id_rt), .id_is_branch(id_is_branch),
      .id_br_ne(id_br_ne), .id_is_jump(id_is_jump), .id_ops_equal(id_ops_equal),
      .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
      .if_flush(if_flush), .pc_redirect(pc_redirect)
   );

   function automatic logic exp_stall();
      return ex_is_load && (ex_rt == id_rs || ex_rt == id_rt);
   endfunction

   function automatic logic exp_redir();
      logic taken;
      taken = id_is_branch && (id_br_ne ? !id_ops_equal : id_ops_equal);
      return (taken || id_is_jump) && !exp_stall();
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      logic s, r;
      s = exp_stall();
      r = exp_redir();
      chk({tag, " R2/R3 pc_we"}, pc_we, !s);
      chk({tag, " R2/R3 ifid_we"}, ifid_we, !s);
      chk({tag, " R1 bubble"}, idex_bubble, s);
      chk({tag, " R4/R5/R6/R7 flush"}, if_flush, r);
      chk({tag, " R4/R5/R6/R7 redirect"}, pc_redirect, r);
   endtask

   task automatic step();
      @(posedge clk); #3;
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int bubbles;
      void'($urandom(32'd1234));
      step();
      chk("R3 reset pc_we", pc_we, 1'b1);
      chk("R3 reset bubble", idex_bubble, 1'b0);
      rst_n = 1;

      // R1 rt match with rs
      ex_is_load = 1; ex_rt = 5'd7; id_rs = 5'd7; id_rt = 5'd3; step();
      check_all("dir_rs");
      // R1 match on rt
      id_rs = 5'd1; id_rt = 5'd7; step();
      check_all("dir_rt");
      // R3 load without dependency
      id_rt = 5'd2; step();
      check_all("dir_nodep");
      // R7 stall with taken branch and with jump
      id_rs = 5'd7; id_is_branch = 1; id_ops_equal = 1; step();
      chk("R7 stall over branch", if_flush, 1'b0);
      id_is_branch = 0; id_is_jump = 1; step();
      chk("R7 stall over jump", pc_redirect, 1'b0);
      // R6 jump, no load
      ex_is_load = 0; step();
      chk("R6 jump flush", if_flush, 1'b1);
      id_is_jump = 0;
      // R8 inverted sense
      id_is_branch = 1; id_br_ne = 1; id_ops_equal = 0; step();
      chk("R8 ne taken", pc_redirect, 1'b1);
      id_ops_equal = 1; step();
      chk("R8 ne not taken R5", if_flush, 1'b0);
      id_br_ne = 0; step();
      chk("R4 eq taken", if_flush, 1'b1);
      id_ops_equal = 0; step();
      chk("R5 eq not taken", pc_redirect, 1'b0);
      id_is_branch = 0;

      // R9 load then dependent and: count bubbles over the sequence
      bubbles = 0;
      ex_is_load = 1; ex_rt = 5'd2; id_rs = 5'd2; id_rt = 5'd5; step();
      if (idex_bubble) bubbles++;
      // consumer held in decode; execute now holds the zeroed instruction
      ex_is_load = 0; ex_rt = 5'd0; step();
      if (idex_bubble) bubbles++;
      chk("R9 consumer advances", ifid_we, 1'b1);
      // consumer moves on; the next instruction is independent
      id_rs = 5'd9; id_rt = 5'd10; ex_is_load = 0; step();
      if (idex_bubble) bubbles++;
      checks++;
      if (bubbles != 1) begin
         errors++;
         $display("FAIL R9 bubbles actual=%0d expected=1", bubbles);
      end

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int kind;
         kind = $urandom_range(0, 2);
         ex_is_load   = $urandom_range(0, 1);
         ex_rt        = RW'($urandom_range(0, 3));
         id_rs        = RW'($urandom_range(0, 3));
         id_rt        = RW'($urandom_range(0, 3));
         id_is_branch = (kind == 1);
         id_is_jump   = (kind == 2);
         id_br_ne     = $urandom_range(0, 1);
         id_ops_equal = $urandom_range(0, 1);
         step();
         check_all("rand");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule